// File: doc/BRIEF.md
# Synchronous Sliced Binary Up-Counter

This block is a wide binary up-counter assembled from identical 4-bit counter slices. Every slice runs on the same clock edge. A slice advances only when the global enable is high and every slice below it holds the value 1111. The chain therefore steps as one wide counter, and every output bit settles after the same single clock edge, with no delay that builds up from one slice to the next.

The number of slices is a parameter. Two slices give an 8-bit counter, three give 12 bits and four give 16 bits. A terminal-count output goes high when the whole counter is at all-ones and enable is high. An outer chain can use it as the enable for a further stage that runs on the same clock. A synchronous, active-high reset clears every slice to zero.

Top module: `slice_chain_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` is zero after that edge.
- R2: When `cnt_en` is low and `rst` is low at a rising edge, `count` keeps its value across that edge.
- R3: The lowest slice (`count[3:0]`) adds one on every enabled edge and goes from 15 back to 0.
- R4: Slice k (bits 4k+3..4k) changes only on an enabled edge where every lower slice is 1111. When that holds, the slice adds one and wraps from 15 to 0.
- R5: With enable held high, the full count runs through every value and goes from all-ones back to zero. This holds for 2, 3 and 4 slices (8, 12 and 16 bits).
- R6: `tc` is high exactly when `cnt_en` is high and every bit of `count` is 1. It follows both in the same cycle, with no register in the path.
- R7: On every enabled edge without reset, the new `count` equals the old `count` plus one, modulo 2^(4·NUM_SLICES). All slices reach that value after the same edge.
- R8: Reset takes priority over `cnt_en`. An edge with both high still gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices (rising edge) |
| rst | input | 1 | Synchronous active-high clear |
| cnt_en | input | 1 | Global count enable |
| count | output | 4·NUM_SLICES | Full counter value, slice 0 in the low nibble |
| tc | output | 1 | Terminal count: all ones and enable high |

## Verification
The bench runs 8-, 12- and 16-bit instances side by side against integer models. It runs them past the full-scale wrap of each, so a carry that skipped a lower slice, or that looked only at the slice directly below, shows up as a wrong nibble at the 0x0F, 0xFF or 0xFFF boundary. An irregular enable pattern catches a design that lets an upper slice move while enable is low, or that registers `tc` and so raises it a cycle late. A reset asserted mid-count together with enable catches an enable that overrides the clear.

// File: rtl/slice_cnt_pkg.sv
package slice_cnt_pkg;
    localparam int SLICE_W = 4;
    typedef logic [SLICE_W-1:0] nibble_t;
    localparam nibble_t NIBBLE_FULL = '1;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import slice_cnt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    output nibble_t q,
    output logic    full
);
    nibble_t q_next;

    always_comb begin
        q_next = q;
        if (en) q_next = q + nibble_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    assign full = (q == NIBBLE_FULL);
endmodule

// File: rtl/slice_en_chain.sv
module slice_en_chain #(
    parameter int NUM_SLICES = 2
) (
    input  logic                  glob_en,
    input  logic [NUM_SLICES-1:0] slice_full,
    output logic [NUM_SLICES-1:0] slice_en,
    output logic                  chain_tc
);
    assign slice_en[0] = glob_en;

    for (genvar k = 1; k < NUM_SLICES; k++) begin : g_link
        assign slice_en[k] = slice_en[k-1] & slice_full[k-1];
    end

    assign chain_tc = slice_en[NUM_SLICES-1] & slice_full[NUM_SLICES-1];
endmodule

// File: rtl/slice_chain_counter.sv
module slice_chain_counter
    import slice_cnt_pkg::*;
#(
    parameter int NUM_SLICES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cnt_en,
    output logic [NUM_SLICES*SLICE_W-1:0]   count,
    output logic                            tc
);
    localparam int CNT_W = NUM_SLICES * SLICE_W;

    logic [NUM_SLICES-1:0] slice_full;
    logic [NUM_SLICES-1:0] slice_en;

    slice_en_chain #(.NUM_SLICES(NUM_SLICES)) u_chain (
        .glob_en    (cnt_en),
        .slice_full (slice_full),
        .slice_en   (slice_en),
        .chain_tc   (tc)
    );

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        nibble_t q_k;
        cnt_slice u_slice (
            .clk  (clk),
            .rst  (rst),
            .en   (slice_en[k]),
            .q    (q_k),
            .full (slice_full[k])
        );
        assign count[k*SLICE_W +: SLICE_W] = q_k;
    end
endmodule

// File: rtl/slice_chain_counter_chk.sv
module slice_chain_counter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count,
    input logic             tc
);
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> count == '0);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> count == CNT_W'($past(count) + CNT_W'(1)));

    a_r4_upper_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count[3:0] != 4'hF) |=> count[CNT_W-1:4] == $past(count[CNT_W-1:4]));

    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        tc |=> count == '0);

    a_r6_tc: assert property (@(posedge clk) disable iff (rst)
        tc == (cnt_en && (&count)));
endmodule

bind slice_chain_counter slice_chain_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count),
    .tc     (tc)
);

// File: tb/slice_chain_counter_tb.sv
module slice_chain_counter_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_en = 1'b0;

    logic [7:0]  cnt8;
    logic [11:0] cnt12;
    logic [15:0] cnt16;
    logic tc8, tc12, tc16;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    int ref_v [3];
    int ref_max [3] = '{255, 4095, 65535};
    bit done = 1'b0;

    always #10 clk = ~clk;

    slice_chain_counter #(.NUM_SLICES(2)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(cnt8), .tc(tc8));
    slice_chain_counter #(.NUM_SLICES(3)) u_dut12 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(cnt12), .tc(tc12));
    slice_chain_counter #(.NUM_SLICES(4)) u_dut16 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(cnt16), .tc(tc16));

    function automatic int get_cnt(int i);
        if (i == 0) return int'(cnt8);
        if (i == 1) return int'(cnt12);
        return int'(cnt16);
    endfunction

    function automatic bit get_tc(int i);
        if (i == 0) return tc8;
        if (i == 1) return tc12;
        return tc16;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle: apply inputs, check tc combinationally, clock, check count.
    task automatic step(bit en_v, bit rst_v);
        string tags [3];
        cnt_en = en_v;
        rst = rst_v;
        #1;
        for (int i = 0; i < 3; i++) begin
            if (!rst_v)
                check("R6 tc", int'(get_tc(i)),
                      int'(en_v && ref_v[i] == ref_max[i]));
            if (rst_v)                        tags[i] = "R1 R8 reset";
            else if (!en_v)                   tags[i] = "R2 hold";
            else if (ref_v[i] == ref_max[i])  tags[i] = "R5 wrap";
            else if ((ref_v[i] & 15) == 15)   tags[i] = "R4 carry";
            else                              tags[i] = "R3 R7 step";
        end
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            if (rst_v)      ref_v[i] = 0;
            else if (en_v)  ref_v[i] = (ref_v[i] + 1) & ref_max[i];
        end
        @(negedge clk);
        for (int i = 0; i < 3; i++) check(tags[i], get_cnt(i), ref_v[i]);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) ref_v[i] = 0;
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R1 reset state", int'(cnt16), 0);

        // R2 R3: irregular enable pattern
        for (int i = 0; i < 60; i++) step((i % 3) != 0 && (i % 7) != 5, 1'b0);

        // R4 R5: free run past the 16-bit wrap
        for (int i = 0; i < 65600; i++) step(1'b1, 1'b0);

        // R8: reset mid-count with enable high
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R8 reset over enable", int'(cnt8), 0);
        for (int i = 0; i < 20; i++) step((i % 2) == 0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule